// File: doc/BRIEF.md
# Gated General-Purpose I/O Port

This block is an 8-bit general-purpose I/O port that sits on a simple memory-mapped register bus. It holds a latched output value, a per-pin direction setting and a read-only view of the pin levels. The pad output-enable follows the direction setting, and the pad output value follows the latched output value.

A neighbouring analog converter supplies a per-pin digital-input-enable vector. When a pin's digital input buffer is switched off, every readback of that pin's level is forced to 1. The data-register readback therefore depends on both the direction bit and the enable bit.

Pin levels pass through a two-flop synchronizer before they reach any readback path. A read returns its data one clock after the address is presented.

Top module: `gpio_port_gate`

## Requirements
- R1: While reset is asserted, the direction register and the output latch are 0. The outputs pad_oe, pad_out and bus_rdata are all 0.
- R2: The synchronizer stages reset to all ones. A read of the input view (offset 0x53) that is sampled at the first clock edge after reset release therefore returns 0xFF, whatever the pin levels.
- R3: Each bit of the input view (offset 0x53) reads 1 when its input-enable bit is 0. It reads the synchronized pin level when its input-enable bit is 1.
- R4: The input view is read-only. A write to offset 0x53 changes neither the direction register nor the output latch.
- R5: The direction register (offset 0x55) can be written and read back at any time. A bit value of 1 makes the pin an output and 0 makes it an input. pad_oe equals the direction bits from the clock after the write.
- R6: The output latch (offset 0x51) can be written at any time, whatever the direction. pad_out equals the latched value from the clock after the write.
- R7: A read of offset 0x51 returns, per bit, the latched bit when the direction bit is 1. When the direction bit is 0 it returns the synchronized pin level if the enable bit is 1, and 1 if the enable bit is 0.
- R8: A pin change that occurs before clock edge k is not seen by reads sampled at edges k and k+1. It is seen by a read sampled at edge k+2.
- R9: bus_rdata is valid in the cycle after bus_rd is high with an address. It is 0 in any cycle that does not follow a read.
- R10: Reads of any other offset return 0. Writes to any other offset change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, one clock after the read strobe |
| in_en | input | 8 | Per-pin digital-input-enable from the converter |
| pad_in | input | 8 | Raw pin levels |
| pad_oe | output | 8 | Per-pin output-enable |
| pad_out | output | 8 | Per-pin output value |

## Verification
The bench builds the block with its default parameters: 8 pins, an 8-bit offset and the offsets 0x51, 0x53 and 0x55. It sweeps four direction patterns, four enable patterns and four pin patterns in every combination, so each bit meets all eight combinations of direction, enable and level. These parameter values also put every gap offset, such as 0x52 and 0x54, and the synchronizer's two-edge delay within reach of direct checks.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_DATA  = 2'd1,
        SEL_INPUT = 2'd2,
        SEL_DIR   = 2'd3
    } port_sel_e;

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_raw,
    output logic [WIDTH-1:0] pin_sync
);

    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = pin_raw;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{s1: '1, s2: '1};
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_sync = st_q.s2;

    // R8: the second stage takes what the first stage held one edge earlier
    p_stage_chain_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> st_q.s2 == $past(st_q.s1));

endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
    import gpio_pkg::*;
#(
    parameter int               WIDTH     = 8,
    parameter int               ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] DATA_OFS  = 8'h51,
    parameter logic [ADDR_W-1:0] INPUT_OFS = 8'h53,
    parameter logic [ADDR_W-1:0] DIR_OFS   = 8'h55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [WIDTH-1:0]  wdata,
    output port_sel_e         sel,
    output logic [WIDTH-1:0]  latch_q,
    output logic [WIDTH-1:0]  dir_q
);

    typedef struct packed {
        logic [WIDTH-1:0] latch;
        logic [WIDTH-1:0] dir;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        if (addr == DATA_OFS)       sel = SEL_DATA;
        else if (addr == INPUT_OFS) sel = SEL_INPUT;
        else if (addr == DIR_OFS)   sel = SEL_DIR;
        else                        sel = SEL_NONE;
    end

    always_comb begin
        r_d = r_q;
        if (wr) begin
            case (sel)
                SEL_DATA: r_d.latch = wdata;
                SEL_DIR:  r_d.dir   = wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign latch_q = r_q.latch;
    assign dir_q   = r_q.dir;

    // R4: writes to the input view leave all state alone
    p_input_ro_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == INPUT_OFS) |=> (r_q == $past(r_q)));

    // R10: writes to unmapped offsets leave all state alone
    p_unmapped_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr != DATA_OFS && addr != DIR_OFS) |=> (r_q == $past(r_q)));

endmodule

// File: rtl/gpio_readback.sv
module gpio_readback
    import gpio_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd,
    input  port_sel_e        sel,
    input  logic [WIDTH-1:0] latch_q,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] in_en,
    input  logic [WIDTH-1:0] pin_sync,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] gated_pin;
    logic [WIDTH-1:0] data_view;
    logic [WIDTH-1:0] rdata_d, rdata_q;

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_bit
            assign gated_pin[gi] = in_en[gi] ? pin_sync[gi] : 1'b1;
            assign data_view[gi] = dir_q[gi] ? latch_q[gi] : gated_pin[gi];
        end
    endgenerate

    always_comb begin
        rdata_d = '0;
        if (rd) begin
            case (sel)
                SEL_DATA:  rdata_d = data_view;
                SEL_INPUT: rdata_d = gated_pin;
                SEL_DIR:   rdata_d = dir_q;
                default:   rdata_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata = rdata_q;

    // R9: no read, no data
    p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> rdata == '0);

    // R3: pins with the input buffer off read as 1 in the input view
    p_gate_force_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && sel == SEL_INPUT) |=> ((rdata | $past(in_en)) == '1));

    // R10: unmapped reads return zero
    p_unmapped_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && sel == SEL_NONE) |=> rdata == '0);

endmodule

// File: rtl/gpio_port_gate.sv
module gpio_port_gate
    import gpio_pkg::*;
#(
    parameter int               WIDTH     = 8,
    parameter int               ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] DATA_OFS  = 8'h51,
    parameter logic [ADDR_W-1:0] INPUT_OFS = 8'h53,
    parameter logic [ADDR_W-1:0] DIR_OFS   = 8'h55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  in_en,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_oe,
    output logic [WIDTH-1:0]  pad_out
);

    port_sel_e        sel;
    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] pin_sync;

    gpio_pin_sync #(.WIDTH(WIDTH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_raw  (pad_in),
        .pin_sync (pin_sync)
    );

    gpio_ctrl_regs #(
        .WIDTH     (WIDTH),
        .ADDR_W    (ADDR_W),
        .DATA_OFS  (DATA_OFS),
        .INPUT_OFS (INPUT_OFS),
        .DIR_OFS   (DIR_OFS)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (bus_addr),
        .wr      (bus_wr),
        .wdata   (bus_wdata),
        .sel     (sel),
        .latch_q (latch_q),
        .dir_q   (dir_q)
    );

    gpio_readback #(.WIDTH(WIDTH)) u_rb (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd       (bus_rd),
        .sel      (sel),
        .latch_q  (latch_q),
        .dir_q    (dir_q),
        .in_en    (in_en),
        .pin_sync (pin_sync),
        .rdata    (bus_rdata)
    );

    assign pad_oe  = dir_q;
    assign pad_out = latch_q;

    // R5: output-enable follows a direction write one clock later
    p_oe_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == DIR_OFS) |=> pad_oe == $past(bus_wdata));

    // R6: output value follows a latch write one clock later
    p_out_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == DATA_OFS) |=> pad_out == $past(bus_wdata));

endmodule

// File: tb/gpio_port_gate_tb.sv
module gpio_port_gate_tb;

    localparam logic [7:0] A_DATA  = 8'h51;
    localparam logic [7:0] A_INPUT = 8'h53;
    localparam logic [7:0] A_DIR   = 8'h55;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] in_en = '0;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_oe;
    logic [7:0] pad_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_port_gate u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .in_en     (in_en),
        .pad_in    (pad_in),
        .pad_oe    (pad_oe),
        .pad_out   (pad_out)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%02h exp=%02h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    function automatic logic [7:0] exp_input(input logic [7:0] en, input logic [7:0] pin);
        return (~en) | pin;
    endfunction

    function automatic logic [7:0] exp_data(input logic [7:0] dir, input logic [7:0] en,
                                            input logic [7:0] pin, input logic [7:0] lat);
        return (dir & lat) | (~dir & exp_input(en, pin));
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] rv, r1, r2, r3;
        logic [7:0] pat [4];
        pat[0] = 8'h00; pat[1] = 8'hFF; pat[2] = 8'hA5; pat[3] = 8'h3C;

        in_en  = 8'hFF;
        pad_in = 8'h00;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 pad_oe", pad_oe, 8'h00);
        check("R1 pad_out", pad_out, 8'h00);
        check("R1 rdata", bus_rdata, 8'h00);
        rst_n = 1'b1;

        // R2: first read after release sees reset value of synchronizer
        bus_read(A_INPUT, rv);
        check("R2 input after reset", rv, 8'hFF);
        repeat (3) @(negedge clk);
        bus_read(A_INPUT, rv);
        check("R3 input settled", rv, 8'h00);
        bus_read(A_DIR, rv);
        check("R1 dir reset", rv, 8'h00);
        @(negedge clk);
        check("R9 idle rdata", bus_rdata, 8'h00);

        // sweep of direction, enable and pin patterns
        for (int di = 0; di < 4; di++) begin
            for (int ei = 0; ei < 4; ei++) begin
                for (int pi = 0; pi < 4; pi++) begin
                    logic [7:0] dir, en, pin, lat;
                    dir = pat[di];
                    en  = pat[ei] ^ 8'h0F;
                    pin = pat[pi] ^ 8'h66;
                    lat = ~pin ^ dir;
                    bus_write(A_DATA, lat);
                    bus_write(A_DIR, dir);
                    in_en  = en;
                    pad_in = pin;
                    repeat (3) @(negedge clk);
                    check("R5 pad_oe", pad_oe, dir);
                    check("R6 pad_out", pad_out, lat);
                    bus_read(A_DATA, rv);
                    check("R7 data view", rv, exp_data(dir, en, pin, lat));
                    bus_read(A_INPUT, rv);
                    check("R3 input view", rv, exp_input(en, pin));
                    bus_read(A_DIR, rv);
                    check("R5 dir readback", rv, dir);
                end
            end
        end

        // R4: writes to input view change nothing
        bus_write(A_DIR, 8'h5A);
        bus_write(A_DATA, 8'hC3);
        in_en = 8'hFF; pad_in = 8'h81;
        repeat (3) @(negedge clk);
        bus_write(A_INPUT, 8'h00);
        bus_write(A_INPUT, 8'hFF);
        bus_read(A_DIR, rv);
        check("R4 dir kept", rv, 8'h5A);
        check("R4 pad_out kept", pad_out, 8'hC3);
        bus_read(A_INPUT, rv);
        check("R4 input view", rv, 8'h81);

        // R10: unmapped offsets
        bus_write(8'h54, 8'hFF);
        bus_write(8'h52, 8'h00);
        bus_write(8'h00, 8'h11);
        check("R10 pad_oe kept", pad_oe, 8'h5A);
        check("R10 pad_out kept", pad_out, 8'hC3);
        bus_read(8'h52, rv);
        check("R10 read 52", rv, 8'h00);
        bus_read(8'h54, rv);
        check("R10 read 54", rv, 8'h00);
        bus_read(8'h00, rv);
        check("R10 read 00", rv, 8'h00);
        bus_read(8'hFF, rv);
        check("R10 read FF", rv, 8'h00);

        // R8: two-edge synchronizer delay
        bus_write(A_DIR, 8'h00);
        in_en = 8'hFF; pad_in = 8'h0F;
        repeat (3) @(negedge clk);
        pad_in = 8'hF0;
        bus_read(A_DATA, r1);
        bus_read(A_DATA, r2);
        bus_read(A_DATA, r3);
        check("R8 edge k", r1, 8'h0F);
        check("R8 edge k+1", r2, 8'h0F);
        check("R8 edge k+2", r3, 8'hF0);
        @(negedge clk);
        check("R9 idle after reads", bus_rdata, 8'h00);

        // R6: latch writable while pins are inputs; output pin readback
        bus_write(A_DATA, 8'h3E);
        check("R6 latch while input", pad_out, 8'h3E);
        bus_write(A_DIR, 8'hFF);
        bus_read(A_DATA, rv);
        check("R7 output readback", rv, 8'h3E);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule